// File: doc/BRIEF.md
# Backlight Command Register Slave

This block sits on a serial command link from a host controller to a display timing controller. It takes 8-bit command words and keeps the backlight state: a 6-bit intensity and a power flag. It also latches a resolution-mode flag. Each word holds a 3-bit register address in its upper bits and 5 data bits below them. The duty register supplies the five low intensity bits. The intensity MSB comes from a discrete active-low pin, and backlight power comes from a second discrete pin. Words sent to any other register address are accepted and discarded.

The block produces an effective backlight level for a downstream PWM stage. This level is the intensity when power is on and the intensity is nonzero, and zero otherwise. A one-cycle strobe marks every change of that level. The serial output never carries data. The serial pins are taken to be synchronous to `clk`, and `clk` runs well above the serial bit rate.

Top module: `bl_cmd_slave`

## Requirements
- R1: While `cs_n` is low, each rising edge of `sclk` (seen at a `clk` edge where `sclk` is high and was low at the previous edge) shifts `mosi` into the word MSB first. A word is committed at the `clk` edge where `cs_n` is first seen high, if at least 8 bits were shifted during the frame. The last 8 bits shifted are used.
- R2: A committed word with address bits [7:5] = 0 sets `qres_mode` to 1 when data bits [4:0] are nonzero, and to 0 when they are zero.
- R3: A committed word with address bits [7:5] = 2 writes data bits [4:0] into `intensity[4:0]` and leaves `intensity[5]` unchanged.
- R4: `intensity[5]` takes the inverse of `bl_msb_n` at each `clk` edge. A high pin clears the bit and a low pin sets it.
- R5: The internal power flag takes the level of `bl_pwr_in` at each `clk` edge.
- R6: `eff_level` is 0 when the power flag is 0 or `intensity` is 0. Otherwise it equals `intensity`, on a scale of 0 to 63.
- R7: During reset and before the first update: `intensity` = 0x20, power = 0, `qres_mode` = 0, `eff_level` = 0, and `level_chg` = 0.
- R8: `miso` is always 0. Committed words with addresses 1 and 3 to 7 change neither `intensity` nor `qres_mode`.
- R9: `level_chg` is 1 in exactly those cycles where `eff_level` differs from its value in the previous cycle.
- R10: A frame of fewer than 8 bits commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial bit clock, sampled by `clk` |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data in, MSB first |
| miso | output | 1 | Serial data out, always 0 |
| bl_msb_n | input | 1 | Active-low source of intensity bit 5 |
| bl_pwr_in | input | 1 | Backlight power enable level |
| qres_mode | output | 1 | 1 = quarter-resolution mode |
| intensity | output | 6 | Raw backlight intensity |
| eff_level | output | 6 | Visible backlight level for PWM |
| level_chg | output | 1 | One-cycle pulse when `eff_level` changes |

## Verification
A duty-register commit and a change on the discrete pins can land on the same `clk` edge. The commit writes the low five bits, the MSB pin writes bit 5, and the power pin gates the result. The bench provokes this by toggling `bl_msb_n` and `bl_pwr_in` in the same cycle that `cs_n` rises to end a duty frame. It then requires that the intensity hold both the new data bits and the new MSB, that `eff_level` reflect the new power level, and that `level_chg` fire once for the combined change. Apart from this case, the bench sweeps every duty value under all four pin combinations and every resolution-data value against an arithmetic model.

// File: rtl/bl_cmd_slave.sv
module bl_cmd_slave #(
  parameter int WORD_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int DUTY_ADDR = 2,
  parameter int RES_ADDR  = 0,
  parameter int RST_LEVEL = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  output logic                  miso,
  input  logic                  bl_msb_n,
  input  logic                  bl_pwr_in,
  output logic                  qres_mode,
  output logic [WORD_W-ADDR_W:0] intensity,
  output logic [WORD_W-ADDR_W:0] eff_level,
  output logic                  level_chg
);
  localparam int DW  = WORD_W - ADDR_W;
  localparam int LW  = DW + 1;
  localparam int CW  = $clog2(WORD_W + 1);

  logic              sclk_q, cs_q, pwr_q;
  logic [WORD_W-1:0] shreg;
  logic [CW-1:0]     cnt;
  logic [LW-1:0]     eff_prev;
  logic              shift_en, commit;
  logic [ADDR_W-1:0] w_addr;
  logic [DW-1:0]     w_data;

  assign shift_en = !cs_n && sclk && !sclk_q;
  assign commit   = cs_n && !cs_q && (cnt == CW'(WORD_W));
  assign w_addr   = shreg[WORD_W-1:DW];
  assign w_data   = shreg[DW-1:0];
  assign miso     = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      shreg  <= '0;
      cnt    <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_n) cnt <= '0;
      else if (shift_en) begin
        shreg <= {shreg[WORD_W-2:0], mosi};
        if (cnt != CW'(WORD_W)) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intensity <= LW'(RST_LEVEL);
      pwr_q     <= 1'b0;
      qres_mode <= 1'b0;
      eff_prev  <= '0;
    end else begin
      pwr_q         <= bl_pwr_in;
      intensity[DW] <= !bl_msb_n;
      eff_prev      <= eff_level;
      if (commit && w_addr == ADDR_W'(DUTY_ADDR)) intensity[DW-1:0] <= w_data;
      if (commit && w_addr == ADDR_W'(RES_ADDR))  qres_mode <= |w_data;
    end
  end

  assign eff_level = (pwr_q && |intensity) ? intensity : '0;
  assign level_chg = eff_level != eff_prev;
endmodule

// File: rtl/bl_cmd_slave_chk.sv
module bl_cmd_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       cs_n,
  input logic       mosi,
  input logic       miso,
  input logic       bl_msb_n,
  input logic       bl_pwr_in,
  input logic       qres_mode,
  input logic [5:0] intensity,
  input logic [5:0] eff_level,
  input logic       level_chg
);
  a_r4_msb_active_low: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> intensity[5] == !$past(bl_msb_n));
  a_r6_off_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    !bl_pwr_in |=> eff_level == 6'd0);
  a_r6_on_powered: assert property (@(posedge clk) disable iff (!rst_n)
    bl_pwr_in |=> eff_level == intensity);
  a_r8_miso_zero: assert property (@(posedge clk) disable iff (!rst_n)
    miso == 1'b0);
  a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    level_chg |-> eff_level != $past(eff_level));
  a_r9_no_strobe_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !level_chg |-> eff_level == $past(eff_level));
  a_r3_duty_needs_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |=> $stable(intensity[4:0]));
  a_r2_res_needs_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |=> $stable(qres_mode));
endmodule

bind bl_cmd_slave bl_cmd_slave_chk u_chk (.*);

// File: tb/bl_cmd_slave_tb.sv
module bl_cmd_slave_tb;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0, bl_msb_n = 0, bl_pwr_in = 0;
  logic miso, qres_mode, level_chg;
  logic [5:0] intensity, eff_level;
  int n_chk = 0, n_fail = 0;
  int m_int = 32, m_pwr = 0, m_q = 0, m_eff = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bl_cmd_slave u_dut (.*);

  task automatic cmp(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_of(int i, int p);
    return (p != 0 && i != 0) ? i : 0;
  endfunction

  task automatic check_all(string req);
    int ne;
    ne = eff_of(m_int, m_pwr);
    cmp({req, " intensity"}, int'(intensity), m_int);
    cmp({req, " eff_level"}, int'(eff_level), ne);
    cmp({req, " level_chg R9"}, int'(level_chg), int'(ne != m_eff));
    cmp({req, " qres_mode"}, int'(qres_mode), m_q);
    cmp("R8 miso", int'(miso), 0);
    m_eff = ne;
  endtask

  task automatic set_pins(int m, int p);
    @(negedge clk);
    bl_msb_n = m[0]; bl_pwr_in = p[0];
    m_int = (m_int & 31) | (m[0] ? 0 : 32);
    m_pwr = p;
    @(negedge clk);
  endtask

  task automatic send(logic [15:0] bits, int n, bit pins, int m, int p);
    logic [7:0] w;
    @(negedge clk);
    cs_n = 0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = bits[i]; sclk = 0;
      @(negedge clk);
      sclk = 1;
      @(negedge clk);
      cmp("R8 miso in frame", int'(miso), 0);
    end
    sclk = 0; cs_n = 1;
    if (pins) begin
      bl_msb_n = m[0]; bl_pwr_in = p[0];
      m_int = (m_int & 31) | (m[0] ? 0 : 32);
      m_pwr = p;
    end
    @(negedge clk);
    w = bits[7:0];
    if (n >= 8) begin
      if (w[7:5] == 3'd2) m_int = (m_int & 32) | int'(w[4:0]);
      if (w[7:5] == 3'd0) m_q = (w[4:0] != 0) ? 1 : 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R7 reset intensity", int'(intensity), 32);
    cmp("R7 reset eff_level", int'(eff_level), 0);
    cmp("R7 reset level_chg", int'(level_chg), 0);
    cmp("R7 reset qres_mode", int'(qres_mode), 0);
    rst_n = 1;
    @(negedge clk);
    check_all("R7 after reset");

    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 2; m++)
        for (int d = 0; d < 32; d++) begin
          set_pins(m, p);
          check_all("R4 R5 R6 pins");
          send({8'h0, 3'd2, 5'(d)}, 8, 0, 0, 0);
          check_all("R1 R3 R6 duty");
          @(negedge clk);
          cmp("R9 steady", int'(level_chg), 0);
        end

    for (int d = 0; d < 32; d++) begin
      send({8'h0, 3'd0, 5'(d)}, 8, 0, 0, 0);
      check_all("R2 resolution");
    end

    for (int a = 1; a < 8; a++) begin
      if (a == 2) continue;
      send({8'h0, 3'(a), 5'(7 + a)}, 8, 0, 0, 0);
      check_all("R8 other address");
      send({8'h0, 3'(a), 5'd0}, 8, 0, 0, 0);
      check_all("R8 other address zero");
    end

    send({8'h0, 3'd2, 5'd21}, 8, 0, 0, 0);
    check_all("R3 preload");
    send({11'h0, 5'b01000}, 5, 0, 0, 0);
    check_all("R10 short frame");
    send({11'h0, 5'b00000}, 7, 0, 0, 0);
    check_all("R10 seven bits");
    send({7'h0, 1'b1, 3'd2, 5'd9}, 9, 0, 0, 0);
    check_all("R1 long frame last 8 bits");

    set_pins(0, 0);
    check_all("R5 power off");
    send({8'h0, 3'd2, 5'd17}, 8, 1, 1, 1);
    check_all("R3 R4 R5 same-cycle commit and pins");
    send({8'h0, 3'd2, 5'd0}, 8, 1, 1, 1);
    check_all("R6 zero intensity powered");
    send({8'h0, 3'd2, 5'd0}, 8, 1, 0, 1);
    check_all("R4 same-cycle msb set");
    @(negedge clk);
    cmp("R9 steady end", int'(level_chg), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule